// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronized Release

This block produces count-enable strobes for three timers from one shared 10-bit prescaler. The prescaler runs on the system clock. Each timer has a 3-bit clock select. It can choose no counting, every system clock, one of four divided rates, or the rising or falling edge of its own external pin. The external pin is synchronized and edge-detected inside the block. Every enable the block drives is a single-cycle strobe in the system clock domain.

An 8-bit control register gives software two bits that matter here. One is a prescaler-reset bit, which clears itself one cycle after it is written. The other is a hold bit. While the hold bit is set, a written reset stays asserted, so the shared prescaler and all divided enables stay frozen while the timers are configured. Writing the hold bit back to zero releases the prescaler. All timers that use a divided rate then start from the same phase in the same cycle.

The last timer has two further divided rates, /16 and /32, chosen with a separate 2-bit fine select.

Top module: `tc_prescaler`

## Requirements
- R1: After reset the control register reads 0x00, the prescaler count is zero and the reset bit is clear.
- R2: The control register is read back combinationally on `rd_data`. Bit 7 is the hold bit, bit 0 is the reset bit, and bits 6..1 are plain storage. A write with `wr_en` high loads all eight bits at the next clock edge.
- R3: With the hold bit clear, a reset bit written as one reads one for exactly one cycle and then clears itself.
- R4: While the hold bit is one, the reset bit keeps its written value. While the reset bit is one, every divided-rate enable (selects 010 to 101 and the fine selects) stays low.
- R5: A write that takes the reset bit to zero lets the prescaler run from zero. Counting the cycle after the write edge as cycle 0, a /N enable first fires in cycle N-1 and then every N cycles.
- R6: Clock-select encoding per timer: 000 stopped, 001 every cycle, 010 /8, 011 /64, 100 /256, 101 /1024, 110 external falling edge, 111 external rising edge. Select bits [3i+2:3i] belong to timer i.
- R7: For the last timer, a fine select of 01 picks /16 and 10 picks /32, overriding the clock select. Values 00 and 11 leave the clock select in control.
- R8: Select 000 never produces an enable. Select 001 produces an enable in every cycle, whatever the state of the reset bit.
- R9: An external pin edge yields exactly one enable. The enable goes high in the cycle that follows the second clock edge after the pin changes. This path is not gated by the prescaler reset.
- R10: All timers that use the same divided rate pulse in the same cycles, because they share one prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| clk_sel | input | 9 | Three 3-bit clock selects, timer i at bits [3i+2:3i] |
| fine_sel | input | 2 | Extra /16 or /32 select for the last timer |
| ext_pin | input | 3 | Asynchronous external clock pins, one per timer |
| cnt_en | output | 3 | Single-cycle count-enable strobes, one per timer |

## Verification
The assertions check on every cycle that the reset bit clears itself, that the hold bit keeps it set, that the stopped and undivided selects behave as stated, and that divided enables stay suppressed while the reset bit is set. They also check that divided and external strobes never last two cycles. Only the bench scenarios can show the release alignment: the first /8, /16 and /64 pulses landing at cycles 7, 15 and 63, and equal-rate timers pulsing together. The bench scenarios also cover the two-edge latency of the external path and the full select space under random mixes of writes and pin activity.

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
  parameter int CNT_W = 10,
  parameter int NT    = 3,
  parameter int SW    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  input  logic [SW*NT-1:0] clk_sel,
  input  logic [1:0]      fine_sel,
  input  logic [NT-1:0]   ext_pin,
  output logic [NT-1:0]   cnt_en
);
  localparam int B8 = 3, B16 = 4, B32 = 5, B64 = 6, B256 = 8, B1K = 10;

  logic [CNT_W-1:0] cnt;
  logic             hold, psr;
  logic [5:0]       spare;
  logic [CNT_W:1]   tap;
  logic [NT-1:0]    s1, s2, s3;
  logic [NT-1:0]    rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= 1'b0;
      spare <= '0;
      psr   <= 1'b0;
    end else if (wr_en) begin
      {hold, spare, psr} <= wr_data;
    end else if (!hold) begin
      psr <= 1'b0;
    end
  end

  assign rd_data = {hold, spare, psr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (psr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  for (genvar k = 1; k <= CNT_W; k++) begin : g_tap
    assign tap[k] = ~psr & (&cnt[k-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= ext_pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic [SW-1:0] sel;
    logic          base;
    assign sel = clk_sel[SW*t +: SW];
    always_comb begin
      case (sel)
        3'b001:  base = 1'b1;
        3'b010:  base = tap[B8];
        3'b011:  base = tap[B64];
        3'b100:  base = tap[B256];
        3'b101:  base = tap[B1K];
        3'b110:  base = fall[t];
        3'b111:  base = rise[t];
        default: base = 1'b0;
      endcase
    end
    if (t == NT-1) begin : g_fine
      always_comb begin
        case (fine_sel)
          2'b01:   cnt_en[t] = tap[B16];
          2'b10:   cnt_en[t] = tap[B32];
          default: cnt_en[t] = base;
        endcase
      end
    end else begin : g_plain
      assign cnt_en[t] = base;
    end
  end
endmodule

// File: rtl/tc_prescaler_chk.sv
module tc_prescaler_chk #(
  parameter int NT = 3,
  parameter int SW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       rd_data,
  input logic [SW*NT-1:0] clk_sel,
  input logic [NT-1:0]    cnt_en
);
  a_r3_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !rd_data[7] && !wr_en) |=> !rd_data[0]);

  a_r4_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && rd_data[7] && !wr_en) |=> rd_data[0]);

  a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && clk_sel[2:0] >= 3'b010 && clk_sel[2:0] <= 3'b101) |-> !cnt_en[0]);

  a_r8_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel[5:3] == 3'b000) |-> !cnt_en[1]);

  a_r8_undivided: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel[2:0] == 3'b001) |-> cnt_en[0]);

  a_r6_div_single: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel[2:0] == 3'b010 && cnt_en[0] && !wr_en) |=>
      (!cnt_en[0] || clk_sel[2:0] != 3'b010));

  a_r9_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel[5:3] == 3'b111 && cnt_en[1]) |=>
      (!cnt_en[1] || clk_sel[5:3] != 3'b111));
endmodule

bind tc_prescaler tc_prescaler_chk #(.NT(NT), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
  .clk_sel(clk_sel), .cnt_en(cnt_en)
);

// File: tb/tc_prescaler_tb.sv
module tc_prescaler_tb;
  logic       clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [8:0] clk_sel = 0;
  logic [1:0] fine_sel = 0;
  logic [2:0] ext_pin = 0, cnt_en;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tc_prescaler u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_sel(clk_sel), .fine_sel(fine_sel),
    .ext_pin(ext_pin), .cnt_en(cnt_en));

  // reference state, built from the requirements
  logic [9:0] m_cnt;
  logic [7:0] m_reg;
  logic [2:0] m1, m2, m3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_reg <= 0; m1 <= 0; m2 <= 0; m3 <= 0;
    end else begin
      if (wr_en) m_reg <= wr_data;
      else if (!m_reg[7]) m_reg[0] <= 1'b0;
      m_cnt <= m_reg[0] ? 10'd0 : m_cnt + 10'd1;
      m1 <= ext_pin; m2 <= m1; m3 <= m2;
    end
  end

  function automatic bit divp(int n);
    return !m_reg[0] && ((int'(m_cnt) % n) == n - 1);
  endfunction

  function automatic bit exp_en(int t);
    logic [2:0] s = clk_sel[3*t +: 3];
    if (t == 2 && fine_sel == 2'b01) return divp(16);
    if (t == 2 && fine_sel == 2'b10) return divp(32);
    case (s)
      3'd1: return 1'b1;
      3'd2: return divp(8);
      3'd3: return divp(64);
      3'd4: return divp(256);
      3'd5: return divp(1024);
      3'd6: return !m2[t] && m3[t];
      3'd7: return m2[t] && !m3[t];
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic cmp_all(string tag);
    logic [2:0] e;
    for (int t = 0; t < 3; t++) e[t] = exp_en(t);
    chk(cnt_en == e, tag, cnt_en, e);
    chk(rd_data == m_reg, "R2 readback", rd_data, m_reg);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int first [3];
    int pulses;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(rd_data == 8'h00, "R1 reset register", rd_data, 0);
    chk(cnt_en == 3'b000, "R1 stopped after reset", cnt_en, 0);
    // R8 undivided
    clk_sel = 9'b001_001_001;
    @(negedge clk);
    chk(cnt_en == 3'b111, "R8 undivided", cnt_en, 7);
    // R2
    wr(8'h7E);
    chk(rd_data == 8'h7E, "R2 spare bits", rd_data, 8'h7E);
    // R3
    wr(8'h01);
    chk(rd_data[0] == 1'b1, "R3 reset bit set", rd_data, 1);
    @(negedge clk);
    chk(rd_data[0] == 1'b0, "R3 reset bit self-clear", rd_data, 0);
    // R4 hold, divided gated, undivided and external not gated (R8, R9)
    clk_sel = 9'b111_001_010;
    wr(8'h81);
    for (int i = 0; i < 40; i++) begin
      chk(rd_data == 8'h81, "R4 held", rd_data, 8'h81);
      chk(cnt_en[0] == 1'b0, "R4 divided gated", cnt_en[0], 0);
      chk(cnt_en[1] == 1'b1, "R8 undivided while held", cnt_en[1], 1);
      @(negedge clk);
    end
    ext_pin[2] = 1'b1;
    @(negedge clk);
    chk(cnt_en[2] == 1'b0, "R9 latency edge1", cnt_en[2], 0);
    @(negedge clk);
    chk(cnt_en[2] == 1'b1, "R9 pulse while held", cnt_en[2], 1);
    @(negedge clk);
    chk(cnt_en[2] == 1'b0, "R9 single pulse", cnt_en[2], 0);
    // R5 and R7: first strobe positions after release
    clk_sel = 9'b000_011_010; fine_sel = 2'b01;
    wr(8'h00);
    first = '{-1, -1, -1};
    for (int i = 0; i < 70; i++) begin
      for (int t = 0; t < 3; t++) if (cnt_en[t] && first[t] < 0) first[t] = i;
      @(negedge clk);
    end
    chk(first[0] == 7, "R5 first /8", first[0], 7);
    chk(first[1] == 63, "R5 first /64", first[1], 63);
    chk(first[2] == 15, "R7 first /16", first[2], 15);
    // R10 alignment
    clk_sel = 9'b010_010_010; fine_sel = 2'b00;
    wr(8'h81);
    wr(8'h00);
    pulses = 0;
    for (int i = 0; i < 24; i++) begin
      chk(cnt_en == 3'b000 || cnt_en == 3'b111, "R10 aligned", cnt_en, {3{cnt_en[0]}});
      if (cnt_en[0]) pulses++;
      @(negedge clk);
    end
    chk(pulses == 3, "R10 pulse count", pulses, 3);
    // R7 /32
    fine_sel = 2'b10;
    for (int i = 0; i < 70; i++) begin cmp_all("R7 fine /32"); @(negedge clk); end
    // random mix for R6, R9
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) begin
        clk_sel = 9'($urandom);
        fine_sel = 2'($urandom);
      end
      if (($urandom % 4) == 0) ext_pin = ext_pin ^ 3'($urandom);
      if (($urandom % 60) == 0) begin
        wr_en = 1; wr_data = 8'($urandom) & 8'h7F;
      end else wr_en = 0;
      #0;
      cmp_all("R6 select mix");
      @(negedge clk);
    end
    wr_en = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule